// File: doc/BRIEF.md
# Serial Register Access Front End with Time Snapshot

This block is the serial slave side of a clock chip. A host frames a transaction by raising chip enable and then clocks bytes through a four-wire serial port: chip enable, serial clock, data in and data out. The first byte of each transaction is a command. Its top bit selects the direction and its low seven bits give the start address. Every later byte moves through an address pointer that advances by one after each byte. The pointer wraps inside whichever of the two regions it started in.

The lower region, 00h to 1Fh, holds the clock registers. Addresses 00h to 06h are the running time and date. The block never serves these from the live counters. It serves them from a shadow copy that is loaded when chip enable rises and loaded again each time the pointer wraps inside this region. A burst read therefore sees one consistent instant, even while the counters move on. The remaining clock-region addresses are read from an outside register file. Writes anywhere in the clock region are passed out as one-cycle byte strobes. The upper region, 20h to 7Fh, is 96 bytes of general RAM held inside the block.

All serial inputs are synchronised into the system clock `clk_i`. That clock must run at least eight times faster than the serial clock.

Top module: `rap_spi_regs`

## Requirements
- R1: The first byte after chip enable rises is a command. Bit 7 set means write and bit 7 clear means read. Bits 6:0 load the address pointer.
- R2: Bits travel MSB first. Data in is sampled on serial clock rising edges. Data out changes only after a serial clock falling edge or a chip enable change. The first read byte is on the line before the 9th rising edge.
- R3: Inside the clock region, the pointer advances by one after each data byte and goes from 1Fh back to 00h.
- R4: Inside the RAM region, the pointer advances by one after each data byte and goes from 7Fh back to 20h.
- R5: A rising chip enable copies `time_i` (byte k at bits 8k+7:8k, address k, k = 0..6) into the shadow copy. Reads of 00h to 06h return the shadow copy, not the live value.
- R6: Each wrap from 1Fh to 00h copies `time_i` into the shadow copy again.
- R7: A completed write byte at a clock-region address raises `reg_we_o` for exactly one cycle, with the address on `reg_addr_o` and the byte on `reg_wdata_o`. Writes to the RAM region raise no strobe.
- R8: The RAM keeps 96 bytes at 20h to 7Fh and returns what was last written there.
- R9: Reads of clock-region addresses 07h to 1Fh return `reg_rdata_i` for the address on `reg_addr_o`.
- R10: Dropping chip enable ends the transaction and clears the bit counter. A partial byte writes nothing, and the next transaction starts with a fresh command byte.
- R11: Serial clock edges while chip enable is low have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, at least 8x the serial clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cs_i | input | 1 | Chip enable, active high |
| sclk_i | input | 1 | Serial clock, idles low |
| mosi_i | input | 1 | Serial data in |
| miso_o | output | 1 | Serial data out, low while chip enable is low |
| time_i | input | 56 | Live time bytes from the counters |
| reg_addr_o | output | 5 | Clock-region address for reads and write strobes |
| reg_wdata_o | output | 8 | Write byte for the clock region |
| reg_we_o | output | 1 | One-cycle clock-region write strobe |
| reg_rdata_i | input | 8 | Read byte of the outside register file |

## Verification
The assertions check the following on every cycle: both pointer wraps, the snapshot reload on a chip-enable rise and on a clock-region wrap, that data out changes only on falling edges, that write strobes stay inside the clock region, and that the bit counter clears when chip enable drops. Some behaviour is visible only at the serial pins, so the directed scenarios cover it. These are: bytes returned MSB first, stale time kept while `time_i` moves, RAM contents across transactions, the outside-register read path, and the way an aborted partial byte or stray serial clocks leave framing and storage untouched.

// File: rtl/rap_pkg.sv
package rap_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned CNT_W  = $clog2(BYTE_W);

  typedef enum logic {
    PH_CMD  = 1'b0,
    PH_DATA = 1'b1
  } phase_e;
endpackage

// File: rtl/rap_sync.sv
module rap_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cs_i,
  input  logic sclk_i,
  input  logic mosi_i,
  output logic cs_o,
  output logic mosi_o,
  output logic cs_rise_o,
  output logic sclk_rise_o,
  output logic sclk_fall_o
);
  localparam int unsigned NSIG = 3;

  logic [NSIG-1:0] raw, synced;
  logic            cs_q, sclk_q, sclk_s;

  assign raw = {cs_i, sclk_i, mosi_i};

  for (genvar g = 0; g < NSIG; g++) begin : g_sync
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain <= '0;
      else         chain <= {chain[STAGES-2:0], raw[g]};
    end
    assign synced[g] = chain[STAGES-1];
  end

  assign cs_o   = synced[2];
  assign sclk_s = synced[1];
  assign mosi_o = synced[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cs_q   <= 1'b0;
      sclk_q <= 1'b0;
    end else begin
      cs_q   <= cs_o;
      sclk_q <= sclk_s;
    end
  end

  // serial clock edges count only inside an active frame
  assign cs_rise_o   = cs_o & ~cs_q;
  assign sclk_rise_o = cs_o & sclk_s & ~sclk_q;
  assign sclk_fall_o = cs_o & ~sclk_s & sclk_q;
endmodule

// File: rtl/rap_frame.sv
module rap_frame
  import rap_pkg::*;
#(
  parameter int unsigned ADDR_W = 7,
  parameter int unsigned CLK_AW = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_i,
  input  logic              sclk_rise_i,
  input  logic              mosi_i,
  output logic              cmd_done_o,
  output logic              data_done_o,
  output logic [BYTE_W-1:0] rx_byte_o,
  output logic [ADDR_W-1:0] ptr_o,
  output logic              write_o,
  output logic              clk_wrap_o,
  output logic [CNT_W-1:0]  bit_cnt_o
);
  localparam logic [ADDR_W-1:0] CLK_LAST = ADDR_W'((1 << CLK_AW) - 1);
  localparam logic [ADDR_W-1:0] RAM_BASE = ADDR_W'(1 << CLK_AW);
  localparam logic [ADDR_W-1:0] PTR_MAX  = ADDR_W'((1 << ADDR_W) - 1);

  phase_e            phase_q;
  logic [CNT_W-1:0]  bit_cnt_q;
  logic [BYTE_W-2:0] sr_q;
  logic [ADDR_W-1:0] ptr_q, ptr_nxt;
  logic              write_q, byte_end;

  assign byte_end    = sclk_rise_i && (bit_cnt_q == CNT_W'(BYTE_W - 1));
  assign rx_byte_o   = {sr_q, mosi_i};
  assign cmd_done_o  = byte_end && (phase_q == PH_CMD);
  assign data_done_o = byte_end && (phase_q == PH_DATA);
  assign clk_wrap_o  = data_done_o && (ptr_q == CLK_LAST);

  always_comb begin
    if (ptr_q == CLK_LAST)     ptr_nxt = '0;
    else if (ptr_q == PTR_MAX) ptr_nxt = RAM_BASE;
    else                       ptr_nxt = ptr_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q   <= PH_CMD;
      bit_cnt_q <= '0;
      sr_q      <= '0;
      ptr_q     <= '0;
      write_q   <= 1'b0;
    end else if (!cs_i) begin
      phase_q   <= PH_CMD;
      bit_cnt_q <= '0;
    end else if (sclk_rise_i) begin
      bit_cnt_q <= bit_cnt_q + 1'b1;
      sr_q      <= {sr_q[BYTE_W-3:0], mosi_i};
      if (cmd_done_o) begin
        ptr_q   <= rx_byte_o[ADDR_W-1:0];
        write_q <= rx_byte_o[BYTE_W-1];
        phase_q <= PH_DATA;
      end else if (data_done_o) begin
        ptr_q   <= ptr_nxt;
      end
    end
  end

  assign ptr_o     = ptr_q;
  assign write_o   = write_q;
  assign bit_cnt_o = bit_cnt_q;
endmodule

// File: rtl/rap_snap.sv
module rap_snap
  import rap_pkg::*;
#(
  parameter int unsigned TIME_BYTES = 7,
  localparam int unsigned TIME_W    = TIME_BYTES * BYTE_W,
  localparam int unsigned SEL_W     = $clog2(TIME_BYTES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              capture_i,
  input  logic [TIME_W-1:0] time_i,
  input  logic [SEL_W-1:0]  sel_i,
  output logic [TIME_W-1:0] snap_o,
  output logic [BYTE_W-1:0] byte_o
);
  logic [TIME_W-1:0] snap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        snap_q <= '0;
    else if (capture_i) snap_q <= time_i;
  end

  always_comb begin
    byte_o = '0;
    for (int k = 0; k < TIME_BYTES; k++) begin
      if (sel_i == SEL_W'(k)) byte_o = snap_q[k*BYTE_W +: BYTE_W];
    end
  end

  assign snap_o = snap_q;
endmodule

// File: rtl/rap_ram.sv
module rap_ram
  import rap_pkg::*;
#(
  parameter int unsigned DEPTH = 96,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [AW-1:0]     addr_i,
  input  logic [BYTE_W-1:0] wdata_i,
  output logic [BYTE_W-1:0] rdata_o
);
  logic [BYTE_W-1:0] mem [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem[addr_i] <= wdata_i;
  end

  assign rdata_o = mem[addr_i];
endmodule

// File: rtl/rap_spi_regs.sv
module rap_spi_regs
  import rap_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned ADDR_W      = 7,
  parameter int unsigned CLK_AW      = 5,
  parameter int unsigned TIME_BYTES  = 7
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       cs_i,
  input  logic                       sclk_i,
  input  logic                       mosi_i,
  output logic                       miso_o,
  input  logic [TIME_BYTES*8-1:0]    time_i,
  output logic [CLK_AW-1:0]          reg_addr_o,
  output logic [7:0]                 reg_wdata_o,
  output logic                       reg_we_o,
  input  logic [7:0]                 reg_rdata_i
);
  localparam int unsigned RAM_BASE  = 1 << CLK_AW;
  localparam int unsigned RAM_DEPTH = (1 << ADDR_W) - RAM_BASE;
  localparam int unsigned RAM_AW    = $clog2(RAM_DEPTH);
  localparam int unsigned TIME_W    = TIME_BYTES * BYTE_W;
  localparam int unsigned TSEL_W    = $clog2(TIME_BYTES);

  logic              cs_s, mosi_s, cs_rise, sclk_rise, sclk_fall;
  logic              cmd_done, data_done, wr_dir, clk_wrap;
  logic [BYTE_W-1:0] rx_byte, rd_byte, ram_rd, snap_byte;
  logic [ADDR_W-1:0] ptr;
  logic [CNT_W-1:0]  bit_cnt;
  logic [TIME_W-1:0] snap_vec;
  logic              in_ram, in_time, ram_we, load_pend_q;
  logic [BYTE_W-1:0] tx_q;
  logic [RAM_AW-1:0] ram_idx;

  rap_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cs_i        (cs_i),
    .sclk_i      (sclk_i),
    .mosi_i      (mosi_i),
    .cs_o        (cs_s),
    .mosi_o      (mosi_s),
    .cs_rise_o   (cs_rise),
    .sclk_rise_o (sclk_rise),
    .sclk_fall_o (sclk_fall)
  );

  rap_frame #(.ADDR_W(ADDR_W), .CLK_AW(CLK_AW)) u_frame (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cs_i        (cs_s),
    .sclk_rise_i (sclk_rise),
    .mosi_i      (mosi_s),
    .cmd_done_o  (cmd_done),
    .data_done_o (data_done),
    .rx_byte_o   (rx_byte),
    .ptr_o       (ptr),
    .write_o     (wr_dir),
    .clk_wrap_o  (clk_wrap),
    .bit_cnt_o   (bit_cnt)
  );

  rap_snap #(.TIME_BYTES(TIME_BYTES)) u_snap (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .capture_i (cs_rise | clk_wrap),
    .time_i    (time_i),
    .sel_i     (ptr[TSEL_W-1:0]),
    .snap_o    (snap_vec),
    .byte_o    (snap_byte)
  );

  assign in_ram  = ptr >= ADDR_W'(RAM_BASE);
  assign in_time = ptr <  ADDR_W'(TIME_BYTES);
  assign ram_idx = RAM_AW'(ptr - ADDR_W'(RAM_BASE));
  assign ram_we  = data_done && wr_dir && in_ram;

  rap_ram #(.DEPTH(RAM_DEPTH)) u_ram (
    .clk_i   (clk_i),
    .we_i    (ram_we),
    .addr_i  (ram_idx),
    .wdata_i (rx_byte),
    .rdata_o (ram_rd)
  );

  assign reg_addr_o  = ptr[CLK_AW-1:0];
  assign reg_wdata_o = rx_byte;
  assign reg_we_o    = data_done && wr_dir && !in_ram;

  always_comb begin
    if (in_ram)       rd_byte = ram_rd;
    else if (in_time) rd_byte = snap_byte;
    else              rd_byte = reg_rdata_i;
  end

  // next byte goes out at the first falling edge after a byte boundary
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_q        <= '0;
      load_pend_q <= 1'b0;
    end else if (!cs_s) begin
      tx_q        <= '0;
      load_pend_q <= 1'b0;
    end else if (cmd_done || data_done) begin
      load_pend_q <= 1'b1;
    end else if (sclk_fall) begin
      load_pend_q <= 1'b0;
      tx_q        <= load_pend_q ? rd_byte : {tx_q[BYTE_W-2:0], 1'b0};
    end
  end

  assign miso_o = cs_s & tx_q[BYTE_W-1];
endmodule

// File: rtl/rap_spi_regs_chk.sv
module rap_spi_regs_chk #(
  parameter int unsigned ADDR_W = 7,
  parameter int unsigned CLK_AW = 5,
  parameter int unsigned TIME_W = 56,
  parameter int unsigned CNT_W  = 3
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cs_s,
  input logic              cs_rise,
  input logic              sclk_fall,
  input logic              data_done,
  input logic [ADDR_W-1:0] ptr,
  input logic [CNT_W-1:0]  bit_cnt,
  input logic [TIME_W-1:0] snap_vec,
  input logic [TIME_W-1:0] time_i,
  input logic              miso_o,
  input logic              reg_we_o
);
  localparam logic [ADDR_W-1:0] CLK_LAST = ADDR_W'((1 << CLK_AW) - 1);
  localparam logic [ADDR_W-1:0] RAM_BASE = ADDR_W'(1 << CLK_AW);
  localparam logic [ADDR_W-1:0] PTR_MAX  = ADDR_W'((1 << ADDR_W) - 1);

  // R3
  clk_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_done && ptr == CLK_LAST) |=> (ptr == '0));

  // R4
  ram_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_done && ptr == PTR_MAX) |=> (ptr == RAM_BASE));

  // R5
  snap_on_cs_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_rise |=> (snap_vec == $past(time_i)));

  // R6
  snap_on_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_done && ptr == CLK_LAST) |=> (snap_vec == $past(time_i)));

  // R2
  miso_fall_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(miso_o) |-> ($past(sclk_fall) || !$stable(cs_s)));

  // R7
  strobe_region_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_o |-> (ptr < RAM_BASE));

  // R10
  cnt_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_s |=> (bit_cnt == '0));
endmodule

bind rap_spi_regs rap_spi_regs_chk #(
  .ADDR_W(ADDR_W), .CLK_AW(CLK_AW), .TIME_W(TIME_W), .CNT_W(rap_pkg::CNT_W)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .cs_s      (cs_s),
  .cs_rise   (cs_rise),
  .sclk_fall (sclk_fall),
  .data_done (data_done),
  .ptr       (ptr),
  .bit_cnt   (bit_cnt),
  .snap_vec  (snap_vec),
  .time_i    (time_i),
  .miso_o    (miso_o),
  .reg_we_o  (reg_we_o)
);

// File: tb/rap_spi_regs_test.sv
module rap_spi_regs_test;
  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 8;
  localparam int TB_BYTES   = 7;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cs = 1'b0, sclk = 1'b0, mosi = 1'b0;
  logic        miso;
  logic [55:0] time_v = '0;
  logic [4:0]  reg_addr;
  logic [7:0]  reg_wdata, reg_rdata;
  logic        reg_we;

  int n_cmp = 0, n_bad = 0, wn = 0;
  logic [4:0] wl_addr [16];
  logic [7:0] wl_data [16];
  logic [55:0] t_a, t_b;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rap_spi_regs uut (
    .clk_i(clk), .rst_ni(rst_n), .cs_i(cs), .sclk_i(sclk), .mosi_i(mosi),
    .miso_o(miso), .time_i(time_v), .reg_addr_o(reg_addr),
    .reg_wdata_o(reg_wdata), .reg_we_o(reg_we), .reg_rdata_i(reg_rdata)
  );

  // outside register file model
  assign reg_rdata = 8'hA0 ^ {3'b000, reg_addr};

  always @(negedge clk) begin
    if (reg_we && wn < 16) begin
      wl_addr[wn] = reg_addr;
      wl_data[wn] = reg_wdata;
    end
    if (reg_we) wn++;
  end

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic spi_begin();
    cs = 1'b1;
    repeat (8) @(negedge clk);
  endtask

  task automatic spi_end();
    repeat (HALF) @(negedge clk);
    cs = 1'b0;
    repeat (8) @(negedge clk);
  endtask

  task automatic spi_bits(input logic [7:0] tx, input int n, output logic [7:0] rx);
    rx = '0;
    for (int i = 0; i < n; i++) begin
      mosi = tx[7-i];
      repeat (HALF) @(negedge clk);
      rx[7-i] = miso;
      sclk = 1'b1;
      repeat (HALF) @(negedge clk);
      sclk = 1'b0;
    end
  endtask

  task automatic spi_byte(input logic [7:0] tx, output logic [7:0] rx);
    spi_bits(tx, 8, rx);
  endtask

  task automatic t_reset();
    chk(miso, 1'b0, "R2 reset miso");
    chk(reg_we, 1'b0, "R7 reset strobe");
  endtask

  task automatic t_snapshot();
    logic [7:0] rx;
    time_v = t_a;
    spi_begin();
    time_v = t_b;
    spi_byte(8'h00, rx);
    for (int k = 0; k < TB_BYTES; k++) begin
      spi_byte(8'h00, rx);
      chk(rx, t_a[k*8 +: 8], "R5 R1 R2 snapshot read");
    end
    spi_end();
  endtask

  task automatic t_reg_read();
    logic [7:0] rx;
    spi_begin();
    spi_byte(8'h07, rx);
    for (int k = 7; k < 10; k++) begin
      spi_byte(8'h00, rx);
      chk(rx, 8'hA0 ^ 8'(k), "R9 outside reg read");
    end
    spi_end();
  endtask

  task automatic t_clk_wrap();
    logic [7:0] rx;
    time_v = t_a;
    spi_begin();
    time_v = t_b;
    spi_byte(8'h1E, rx);
    spi_byte(8'h00, rx); chk(rx, 8'hBE, "R9 read 1Eh");
    spi_byte(8'h00, rx); chk(rx, 8'hBF, "R3 read 1Fh");
    spi_byte(8'h00, rx); chk(rx, t_b[7:0], "R3 R6 wrapped read 00h");
    spi_byte(8'h00, rx); chk(rx, t_b[15:8], "R6 wrapped read 01h");
    spi_end();
  endtask

  task automatic t_ram_wrap();
    logic [7:0] rx;
    wn = 0;
    spi_begin();
    spi_byte(8'hFE, rx);
    spi_byte(8'h11, rx);
    spi_byte(8'h22, rx);
    spi_byte(8'h33, rx);
    spi_end();
    chk(wn, 0, "R7 no strobe for RAM");
    spi_begin();
    spi_byte(8'h7E, rx);
    spi_byte(8'h00, rx); chk(rx, 8'h11, "R8 RAM 7Eh");
    spi_byte(8'h00, rx); chk(rx, 8'h22, "R8 RAM 7Fh");
    spi_byte(8'h00, rx); chk(rx, 8'h33, "R4 RAM wrap to 20h");
    spi_end();
    spi_begin();
    spi_byte(8'h20, rx);
    spi_byte(8'h00, rx); chk(rx, 8'h33, "R4 RAM 20h direct");
    spi_end();
  endtask

  task automatic t_reg_write();
    logic [7:0] rx;
    wn = 0;
    spi_begin();
    spi_byte(8'h83, rx);
    spi_byte(8'h5A, rx);
    spi_byte(8'hC3, rx);
    spi_end();
    chk(wn, 2, "R7 strobe count");
    chk(wl_addr[0], 5'h03, "R7 first addr");
    chk(wl_data[0], 8'h5A, "R7 first data");
    chk(wl_addr[1], 5'h04, "R7 second addr");
    chk(wl_data[1], 8'hC3, "R7 second data");
  endtask

  task automatic t_abort();
    logic [7:0] rx;
    wn = 0;
    spi_begin();
    spi_byte(8'h85, rx);
    spi_bits(8'hFF, 4, rx);
    spi_end();
    chk(wn, 0, "R10 partial byte no strobe");
    spi_begin();
    spi_byte(8'hC0, rx);
    spi_byte(8'h77, rx);
    spi_byte(8'h12, rx);
    spi_end();
    spi_begin();
    spi_byte(8'hC1, rx);
    spi_bits(8'hEE, 5, rx);
    spi_end();
    spi_begin();
    spi_byte(8'h40, rx);
    spi_byte(8'h00, rx); chk(rx, 8'h77, "R10 fresh command after abort");
    spi_byte(8'h00, rx); chk(rx, 8'h12, "R10 partial RAM byte discarded");
    spi_end();
  endtask

  task automatic t_idle_sclk();
    logic [7:0] rx;
    wn = 0;
    mosi = 1'b1;
    for (int i = 0; i < 12; i++) begin
      repeat (HALF) @(negedge clk); sclk = 1'b1;
      repeat (HALF) @(negedge clk); sclk = 1'b0;
    end
    chk(miso, 1'b0, "R11 miso idle");
    chk(wn, 0, "R11 no strobe while idle");
    spi_begin();
    spi_byte(8'h40, rx);
    spi_byte(8'h00, rx); chk(rx, 8'h77, "R11 framing intact");
    spi_end();
  endtask

  initial begin
    for (int k = 0; k < TB_BYTES; k++) begin
      t_a[k*8 +: 8] = 8'h10 + 8'(k);
      t_b[k*8 +: 8] = 8'h50 + 8'(k);
    end
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_snapshot();
    t_reg_read();
    t_clk_wrap();
    t_ram_wrap();
    t_reg_write();
    t_abort();
    t_idle_sclk();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule